// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block keeps a small first-in first-out store of instruction bytes filled ahead of an instruction decoder. It holds a 16-bit code base and a 16-bit fetch offset. It forms a 20-bit physical fetch address by shifting the base left four bits and adding the offset. Whenever at least two byte slots are free, it reads a 16-bit word over the memory bus. The decoder then takes the fetched bytes one per cycle through a valid/take pair.

The same memory bus also carries data reads and writes for the execution side. A data request that arrives while the bus is idle wins over a prefetch. A data request that arrives during a fetch waits until that fetch has finished. When a jump is taken, the queue is emptied and the base and offset are reloaded. A fetch that is still on the bus at that moment runs to completion, but its bytes are thrown away. The decoder sees no valid byte until bytes from the target address arrive.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is held, `byte_valid` and `queue_full` are 0, `queue_empty` is 1 and `mem_req` is 0. The first fetch after reset uses physical address `{RST_SEG,4'h0} + RST_OFF`, which is 0 by default.
- R2: Bytes reach `byte_out` in the order of ascending code address, starting at the current target. Each cycle with `byte_valid` and `byte_take` high removes exactly one byte.
- R3: A fetch starts only when at least two of the DEPTH slots (default 6) are free, so the queue never overflows. With the consumer stalled, an even start address fills the queue to `queue_full`. An odd start address leaves one slot free. In both cases the bus then stays idle.
- R4: A fetch address equals `{base,4'h0} + offset`, truncated to 20 bits.
- R5: If the offset is even, one fetch queues the low lane `mem_rdata[7:0]` and then the high lane `mem_rdata[15:8]`, and the offset advances by 2. If the offset is odd, only the high lane is queued and the offset advances by 1.
- R6: When the bus is idle, a data request (`dreq`) is started before any prefetch. It drives `mem_addr=daddr` and drives `mem_wr` for writes (`dwe=1`) or `mem_rd` for reads. `dack` pulses in the cycle `mem_ready` completes it, and `drdata` is valid in that cycle.
- R7: A bus transfer, once started, holds `mem_req` and `mem_addr` until `mem_ready`. A data request that arrives during a fetch therefore waits, and at most one fetch completes between the rise of `dreq` and its `dack`.
- R8: A `jump_valid` pulse loads the base and offset and empties the queue, so `byte_valid` is 0 in the following cycle.
- R9: A fetch in flight when a jump arrives completes on the bus, but its bytes are not queued. The next fetch uses the target address.
- R10: A `byte_take` while the queue is empty, or in the same cycle as `jump_valid`, has no effect on the byte stream.
- R11: When the bus is idle, with no data request, no jump and at least two slots free, a fetch is on the bus in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| jump_valid | input | 1 | Taken jump, one-cycle pulse |
| jump_seg | input | 16 | New code base |
| jump_off | input | 16 | New fetch offset |
| byte_out | output | 8 | Oldest queued byte |
| byte_valid | output | 1 | byte_out holds a queued byte |
| byte_take | input | 1 | Consumer removes the oldest byte |
| queue_full | output | 1 | All slots occupied |
| queue_empty | output | 1 | No slots occupied |
| dreq | input | 1 | Data access request, held until dack |
| dwe | input | 1 | 1 for a data write, 0 for a data read |
| daddr | input | 20 | Data physical address |
| dwdata | input | 16 | Data write value |
| dack | output | 1 | Data access completes this cycle |
| drdata | output | 16 | Data read value, valid with dack |
| mem_req | output | 1 | Bus transfer in progress |
| mem_addr | output | 20 | Bus physical address |
| mem_rd | output | 1 | Transfer is a read |
| mem_wr | output | 1 | Transfer is a write |
| mem_wdata | output | 16 | Bus write data |
| mem_ready | input | 1 | Memory completes the transfer this cycle |
| mem_rdata | input | 16 | Memory read word |

## Verification
The assertions assume the following about the environment:
- `dreq` and its address, data and direction stay steady from the rise of `dreq` until the `dack` cycle, and `dreq` drops right after that cycle.
- `mem_ready` comes only while `mem_req` is high.
- Code and data addresses do not make the offset wrap.

The stimulus keeps to these limits:
- The memory model raises `mem_ready` only for a live request, after a latency of zero to three cycles.
- The data task drops `dreq` before the clock edge that follows `dack`.
- Code runs stay far below the data region at 0xF0000 and above.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int SEG_W  = 16;
  localparam int OFF_W  = 16;
  localparam int PA_W   = SEG_W + 4;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    BUS_IDLE  = 2'd0,
    BUS_FETCH = 2'd1,
    BUS_DATA  = 2'd2
  } bus_state_t;

  // 20-bit physical address: base shifted by one nibble plus offset
  function automatic logic [PA_W-1:0] phys_addr(input logic [SEG_W-1:0] seg,
                                                input logic [OFF_W-1:0] off);
    return {seg, 4'h0} + PA_W'(off);
  endfunction

  // bytes taken from one fetch: a single high lane byte at odd offsets
  function automatic logic [1:0] fetch_bytes(input logic [OFF_W-1:0] off);
    return off[0] ? 2'd1 : 2'd2;
  endfunction
endpackage

// File: rtl/pfq_byte_store.sv
module pfq_byte_store #(
  parameter int DEPTH = 6,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    push_n,
  input  logic [7:0]    push_first,
  input  logic [7:0]    push_second,
  input  logic          pop,
  output logic [7:0]    head,
  output logic [CW-1:0] fill
);
  logic [7:0]    slot [DEPTH];
  logic [PW-1:0] rd_ix, wr_ix;
  logic          pop_ok;

  function automatic logic [PW-1:0] wrap_add(input logic [PW-1:0] ix, input int n);
    int t;
    t = int'(ix) + n;
    if (t >= DEPTH) t = t - DEPTH;
    return PW'(t);
  endfunction

  assign pop_ok = pop && (fill != '0) && !flush;
  assign head   = slot[rd_ix];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_ix <= '0;
      wr_ix <= '0;
      fill  <= '0;
    end else begin
      wr_ix <= wrap_add(wr_ix, int'(push_n));
      rd_ix <= wrap_add(rd_ix, int'(pop_ok));
      fill  <= fill + CW'(push_n) - CW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!flush && push_n != 2'd0) slot[wr_ix] <= push_first;
    if (!flush && push_n == 2'd2) slot[wrap_add(wr_ix, 1)] <= push_second;
  end
endmodule

// File: rtl/pfq_bus_seq.sv
module pfq_bus_seq
  import pfq_pkg::*;
#(
  parameter int AW = PA_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          dreq,
  input  logic          dwe,
  input  logic [AW-1:0] daddr,
  input  logic [DW-1:0] dwdata,
  input  logic          fetch_ok,
  input  logic [AW-1:0] fetch_addr,
  input  logic          mem_ready,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  output logic          dack,
  output logic          fetch_start,
  output logic          fetch_done,
  output logic          bus_idle,
  output logic          bus_fetch,
  output logic          bus_data
);
  bus_state_t    state;
  logic          we_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wd_q;
  logic          data_start;

  assign bus_idle    = (state == BUS_IDLE);
  assign bus_fetch   = (state == BUS_FETCH);
  assign bus_data    = (state == BUS_DATA);
  assign data_start  = bus_idle && dreq;
  assign fetch_start = bus_idle && !dreq && fetch_ok;
  assign fetch_done  = bus_fetch && mem_ready;
  assign dack        = bus_data && mem_ready;

  assign mem_req   = !bus_idle;
  assign mem_addr  = addr_q;
  assign mem_rd    = mem_req && !we_q;
  assign mem_wr    = mem_req && we_q;
  assign mem_wdata = wd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= BUS_IDLE;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      unique case (state)
        BUS_IDLE: begin
          if (data_start) begin
            state  <= BUS_DATA;
            addr_q <= daddr;
            we_q   <= dwe;
            wd_q   <= dwdata;
          end else if (fetch_start) begin
            state  <= BUS_FETCH;
            addr_q <= fetch_addr;
            we_q   <= 1'b0;
          end
        end
        BUS_FETCH, BUS_DATA: if (mem_ready) state <= BUS_IDLE;
        default: state <= BUS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prefetch_queue.sv
module prefetch_queue
  import pfq_pkg::*;
#(
  parameter int            DEPTH   = 6,
  parameter logic [15:0]   RST_SEG = 16'h0000,
  parameter logic [15:0]   RST_OFF = 16'h0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        jump_valid,
  input  logic [15:0] jump_seg,
  input  logic [15:0] jump_off,
  output logic [7:0]  byte_out,
  output logic        byte_valid,
  input  logic        byte_take,
  output logic        queue_full,
  output logic        queue_empty,
  input  logic        dreq,
  input  logic        dwe,
  input  logic [19:0] daddr,
  input  logic [15:0] dwdata,
  output logic        dack,
  output logic [15:0] drdata,
  output logic        mem_req,
  output logic [19:0] mem_addr,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic [15:0] mem_wdata,
  input  logic        mem_ready,
  input  logic [15:0] mem_rdata
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SEG_W-1:0] cs_q;
  logic [OFF_W-1:0] ip_q;
  logic             drop_q;
  logic [CW-1:0]    fill_cnt;
  logic             room_for_word;
  logic             fetch_ok;
  logic             fetch_start, fetch_done, fetch_accept;
  logic             bus_idle, bus_fetch, bus_data;
  logic [1:0]       push_n;
  logic [7:0]       push_first;

  assign room_for_word = (fill_cnt <= CW'(DEPTH - 2));
  assign fetch_ok      = !jump_valid && room_for_word;
  assign fetch_accept  = fetch_done && !drop_q && !jump_valid;
  assign push_n        = fetch_accept ? fetch_bytes(ip_q) : 2'd0;
  assign push_first    = ip_q[0] ? mem_rdata[15:8] : mem_rdata[7:0];

  pfq_bus_seq #(.AW(PA_W), .DW(WORD_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .dreq(dreq), .dwe(dwe), .daddr(daddr), .dwdata(dwdata),
    .fetch_ok(fetch_ok), .fetch_addr(phys_addr(cs_q, ip_q)),
    .mem_ready(mem_ready),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .dack(dack),
    .fetch_start(fetch_start), .fetch_done(fetch_done),
    .bus_idle(bus_idle), .bus_fetch(bus_fetch), .bus_data(bus_data)
  );

  pfq_byte_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(jump_valid),
    .push_n(push_n), .push_first(push_first), .push_second(mem_rdata[15:8]),
    .pop(byte_take), .head(byte_out), .fill(fill_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q   <= RST_SEG;
      ip_q   <= RST_OFF;
      drop_q <= 1'b0;
    end else begin
      if (jump_valid) begin
        cs_q <= jump_seg;
        ip_q <= jump_off;
      end else if (fetch_accept) begin
        ip_q <= ip_q + OFF_W'(fetch_bytes(ip_q));
      end
      if (jump_valid && bus_fetch && !mem_ready) drop_q <= 1'b1;
      else if (fetch_done)                       drop_q <= 1'b0;
    end
  end

  assign drdata      = mem_rdata;
  assign byte_valid  = (fill_cnt != '0);
  assign queue_empty = (fill_cnt == '0);
  assign queue_full  = (fill_cnt == CW'(DEPTH));
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DEPTH = 6,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          jump_valid,
  input logic          dreq,
  input logic          dack,
  input logic          mem_req,
  input logic          mem_ready,
  input logic [19:0]   mem_addr,
  input logic          byte_valid,
  input logic [CW-1:0] fill_cnt,
  input logic          bus_idle,
  input logic          bus_data,
  input logic          fetch_start,
  input logic          fetch_accept,
  input logic [15:0]   cs_q,
  input logic [15:0]   ip_q
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  assert_fetch_room_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |-> (CW'(DEPTH) - fill_cnt) >= CW'(2));

  assert_fetch_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_start |=> mem_addr == ({$past(cs_q), 4'h0} + {4'h0, $past(ip_q)}));

  assert_offset_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_accept |=> ip_q == $past(ip_q) + ($past(ip_q[0]) ? 16'd1 : 16'd2));

  assert_data_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && dreq) |=> bus_data);

  assert_dack_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dack |-> (mem_ready && mem_req));

  assert_hold_until_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)));

  assert_flush_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
    jump_valid |=> !byte_valid);

  assert_background_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_idle && !dreq && !jump_valid && fill_cnt <= CW'(DEPTH - 2)) |=> mem_req);
endmodule

bind prefetch_queue pfq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .jump_valid(jump_valid), .dreq(dreq), .dack(dack),
  .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .byte_valid(byte_valid), .fill_cnt(fill_cnt), .bus_idle(bus_idle),
  .bus_data(bus_data), .fetch_start(fetch_start), .fetch_accept(fetch_accept),
  .cs_q(cs_q), .ip_q(ip_q)
);

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump_valid = 1'b0;
  logic [15:0] jump_seg = '0, jump_off = '0;
  logic [7:0]  byte_out;
  logic        byte_valid, byte_take = 1'b0, queue_full, queue_empty;
  logic        dreq = 1'b0, dwe = 1'b0;
  logic [19:0] daddr = '0;
  logic [15:0] dwdata = '0;
  logic        dack;
  logic [15:0] drdata;
  logic        mem_req, mem_rd, mem_wr;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;

  always #4 clk = ~clk;

  prefetch_queue dut (.*);

  int n_chk = 0, n_fail = 0;
  byte unsigned exp_q[$];
  logic [19:0] exp_next = '0;
  bit   cons_en = 0, greedy = 0, jmp_req = 0, after_jump = 0, stale = 0;
  logic [15:0] jseg_req, joff_req;
  int   lat_mode = 0, txn = 0, wait_c = 0, pace = 0;
  int   fetch_cnt = 0, stale_seen = 0;
  logic [19:0] w_addr_exp = '0;
  logic [15:0] w_data_exp = '0;
  string cur_tag = "R2";

  function automatic logic [7:0] code_byte(input logic [19:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ {4'h0, a[19:16]} ^ 8'hA5;
  endfunction

  function automatic void chk(input bit ok, input string tag,
                              input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endfunction

  // scoreboard driver: expected byte stream from a target address
  function automatic void push_expected(input logic [19:0] base);
    exp_q.delete();
    for (int i = 0; i < 400; i++) exp_q.push_back(code_byte(base + 20'(i)));
  endfunction

  // memory model, then jump and consumer monitor, all at the falling edge
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ready = 1'b0;
      wait_c = 0;
    end else begin
      if (mem_ready) begin
        mem_ready = 1'b0;
        wait_c = 0;
        txn++;
      end else if (mem_req) begin
        if (wait_c >= ((lat_mode == 3) ? 3 : (txn % 3))) begin
          mem_ready = 1'b1;
          mem_rdata = {code_byte({mem_addr[19:1], 1'b1}), code_byte({mem_addr[19:1], 1'b0})};
          if (mem_rd && mem_addr < 20'hF0000) begin
            fetch_cnt++;
            if (stale) begin
              stale = 0;
              stale_seen++;
            end else begin
              chk(mem_addr == exp_next, "R4,R5 fetch address", mem_addr, exp_next);
              exp_next = exp_next + (mem_addr[0] ? 20'd1 : 20'd2);
            end
          end
          if (mem_wr) begin
            chk(mem_addr == w_addr_exp, "R6 write address", mem_addr, w_addr_exp);
            chk(mem_wdata == w_data_exp, "R6 write data", mem_wdata, w_data_exp);
          end
        end else begin
          wait_c++;
        end
      end

      if (jmp_req) begin
        jump_valid = 1'b1;
        jump_seg = jseg_req;
        jump_off = joff_req;
        byte_take = greedy;
        if (mem_req && mem_rd && mem_addr < 20'hF0000 && !mem_ready) stale = 1;
        exp_next = {jseg_req, 4'h0} + {4'h0, joff_req};
        push_expected(exp_next);
        jmp_req = 0;
        after_jump = 1;
      end else begin
        jump_valid = 1'b0;
        if (after_jump) begin
          chk(!byte_valid, "R8 valid after jump", byte_valid, 0);
          after_jump = 0;
        end
        pace++;
        byte_take = 1'b0;
        if (cons_en && (greedy || (pace % 3) != 0)) begin
          byte_take = 1'b1;
          if (byte_valid) begin
            if (exp_q.size() == 0) chk(0, cur_tag, byte_out, 0);
            else begin
              automatic logic [7:0] e = exp_q.pop_front();
              chk(byte_out == e, cur_tag, byte_out, e);
            end
          end
        end
      end
    end
  end

  task automatic do_jump(input logic [15:0] s, input logic [15:0] o);
    @(posedge clk);
    jseg_req = s;
    joff_req = o;
    jmp_req = 1;
    @(negedge clk);
    #1;
  endtask

  task automatic data_access(input bit we, input logic [19:0] a, input logic [15:0] wd);
    int f0;
    @(negedge clk);
    #1;
    dreq = 1'b1; dwe = we; daddr = a; dwdata = wd;
    w_addr_exp = a; w_data_exp = wd;
    f0 = fetch_cnt;
    forever begin
      @(negedge clk);
      #1;
      if (dack) break;
    end
    if (!we) chk(drdata == {code_byte(a | 20'd1), code_byte(a & ~20'd1)}, "R6 read data",
                 drdata, {code_byte(a | 20'd1), code_byte(a & ~20'd1)});
    chk((fetch_cnt - f0) <= 1, "R7 fetches before data", fetch_cnt - f0, 1);
    dreq = 1'b0;
  endtask

  task automatic quiet_bus(input string tag);
    int busy = 0;
    repeat (10) begin
      @(negedge clk);
      #1;
      if (mem_req) busy++;
    end
    chk(busy == 0, tag, busy, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    push_expected(20'h0);
    repeat (3) @(negedge clk);
    #1;
    chk(!byte_valid, "R1 byte_valid in reset", byte_valid, 0);
    chk(queue_empty, "R1 queue_empty in reset", queue_empty, 1);
    chk(!queue_full, "R1 queue_full in reset", queue_full, 0);
    chk(!mem_req, "R1 mem_req in reset", mem_req, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(mem_req, "R11 fetch starts after reset", mem_req, 1);
    chk(mem_addr == 20'h0, "R1 first fetch address", mem_addr, 0);

    cons_en = 1;
    repeat (100) @(posedge clk);

    // even start, stalled consumer: queue fills to the top
    cons_en = 0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    #1;
    chk(queue_full, "R3 full with even start", queue_full, 1);
    quiet_bus("R3 bus idle when full");

    // odd target with consumer running
    cons_en = 1;
    cur_tag = "R5";
    do_jump(16'h1234, 16'h0011);
    repeat (60) @(posedge clk);

    // odd target, stalled: one slot stays free
    cons_en = 0;
    do_jump(16'h0200, 16'h0003);
    repeat (40) @(posedge clk);
    @(negedge clk);
    #1;
    chk(!queue_full && byte_valid, "R3 odd start leaves a slot", queue_full, 0);
    quiet_bus("R3 bus idle with one slot");
    cons_en = 1;
    cur_tag = "R2";
    repeat (50) @(posedge clk);

    // jump while a fetch is on the bus
    lat_mode = 3;
    cur_tag = "R9";
    begin
      bit prev = 1;
      forever begin
        @(negedge clk);
        #1;
        if (mem_req && mem_rd && !prev) break;
        prev = mem_req;
      end
    end
    do_jump(16'h0400, 16'h0020);
    repeat (40) @(posedge clk);
    chk(stale_seen > 0, "R9 in-flight fetch dropped", stale_seen, 1);
    lat_mode = 0;

    // data accesses with prefetch running
    cur_tag = "R2";
    data_access(0, 20'hF1002, 16'h0);
    data_access(1, 20'hF2004, 16'hBEEF);
    repeat (5) @(posedge clk);
    data_access(0, 20'hF3007, 16'h0);
    data_access(1, 20'hF0010, 16'h1357);
    repeat (20) @(posedge clk);

    // greedy consumer: takes on empty and on the jump cycle
    greedy = 1;
    cur_tag = "R10";
    do_jump(16'h0800, 16'h0041);
    repeat (60) @(posedge clk);
    do_jump(16'h0801, 16'h0002);
    repeat (60) @(posedge clk);
    greedy = 0;
    cons_en = 0;
    repeat (5) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule